// File: doc/BRIEF.md
# Acquisition Trigger Combiner with Sticky Status

This block merges three trigger sources into one acquisition start pulse. The sources are a software request, a trigger passed on from a neighbouring acquisition unit, and a hardware trigger line. It also raises a buffer-freeze request from a software bit or a hardware line. Every event leaves a sticky flag in a six-bit status word, and a 32-bit counter records how many acquisitions were started.

All control bits and raw lines go through rising-edge detectors in the data clock domain. A level held high therefore produces one event only. The cascade source and the hardware freeze source each have an enable level. The hardware source fires only while it is armed, unless auto-rearm is set. A single clear bit drops all sticky flags on its rising edge. Register decoding and the data path are outside this block.

Top module: `daq_trig_ctrl`

## Requirements
- R1: A rising edge on `ctl_sw_trig` gives `trig_pulse` high for exactly one cycle, registered on the edge that samples the rise. Holding the bit high gives no further pulse.
- R2: A rising edge on `casc_trig_in` triggers only while `ctl_casc_en` is 1. With `ctl_casc_en` at 0 it is ignored: no pulse, no status bit, no count.
- R3: A rising edge on `hw_trig_in` triggers when `ctl_auto_rearm` is 1 or the block is armed. Otherwise it is ignored.
- R4: Status bit 3 (armed) sets on a rising edge of `ctl_arm` and clears when a hardware trigger is accepted. If both happen in the same cycle, the new arming wins.
- R5: The sticky flags latch on their first event and hold until `ctl_clr` has a rising edge. They sit at status bit 0 (software), bit 1 (cascade), bit 2 (hardware) and bit 4 (any accepted trigger). An event in the same cycle as the clear edge keeps its flag set.
- R6: `freeze_req` pulses for one cycle on a rising edge of `ctl_sw_freeze`. It also pulses on a rising edge of `hw_freeze_in` while `ctl_hw_freeze_en` is 1. Status bit 5 is the sticky freeze flag, and it clears under the same rule as R5.
- R7: `trig_count` rises by exactly one in every cycle in which `trig_pulse` is high, and it is otherwise unchanged.
- R8: Synchronous active-high `rst` clears the outputs, the status, the count, the armed state and the edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_sw_trig | input | 1 | Software trigger control bit |
| ctl_casc_en | input | 1 | Cascade trigger enable level |
| ctl_auto_rearm | input | 1 | Hardware trigger always armed when 1 |
| ctl_arm | input | 1 | Arms the hardware trigger on its rising edge |
| ctl_clr | input | 1 | Clears the sticky status on its rising edge |
| ctl_sw_freeze | input | 1 | Software freeze control bit |
| ctl_hw_freeze_en | input | 1 | Hardware freeze enable level |
| casc_trig_in | input | 1 | Cascaded trigger line |
| hw_trig_in | input | 1 | Hardware trigger line |
| hw_freeze_in | input | 1 | Hardware freeze line |
| trig_pulse | output | 1 | Combined one-cycle acquisition start |
| freeze_req | output | 1 | One-cycle freeze request |
| status | output | 6 | Sticky and armed flags |
| trig_count | output | 32 | Accepted trigger count |

## Verification
Two pairs of functions can meet in one cycle. A clear edge can land on a new trigger or freeze event, and an arm edge can land on an accepted hardware trigger. The bench forces both collisions deliberately, by driving the two edges on the same clock. It also meets them often during long runs of random toggling. Each cycle the outcome is judged against a behavioural model, in which the event beats the clear and the new arming beats the consumption.

// File: rtl/daq_trig_pkg.sv
package daq_trig_pkg;
  localparam int STS_W      = 6;
  localparam int STS_SW     = 0;
  localparam int STS_CASC   = 1;
  localparam int STS_HW     = 2;
  localparam int STS_ARMED  = 3;
  localparam int STS_ANY    = 4;
  localparam int STS_FREEZE = 5;
  localparam int CNT_W      = 32;
endpackage

// File: rtl/daq_rise_det.sv
module daq_rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/daq_sticky_flags.sv
module daq_sticky_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/daq_trig_counter.sv
module daq_trig_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/daq_trig_ctrl.sv
module daq_trig_ctrl
  import daq_trig_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_sw_trig,
  input  logic             ctl_casc_en,
  input  logic             ctl_auto_rearm,
  input  logic             ctl_arm,
  input  logic             ctl_clr,
  input  logic             ctl_sw_freeze,
  input  logic             ctl_hw_freeze_en,
  input  logic             casc_trig_in,
  input  logic             hw_trig_in,
  input  logic             hw_freeze_in,
  output logic             trig_pulse,
  output logic             freeze_req,
  output logic [STS_W-1:0] status,
  output logic [CW-1:0]    trig_count
);
  localparam int NEDGE = 7;
  localparam int NFLAG = 5;

  logic [NEDGE-1:0] lvl, rise;
  logic sw_r, casc_r, hw_r, arm_r, clr_r, swf_r, hwf_r;
  logic sw_ok, casc_ok, hw_ok, any_ok, frz_ok;
  logic armed_q;
  logic [NFLAG-1:0] evt, flg;

  assign lvl = {hw_freeze_in, ctl_sw_freeze, ctl_clr, ctl_arm,
                hw_trig_in, casc_trig_in, ctl_sw_trig};
  assign {hwf_r, swf_r, clr_r, arm_r, hw_r, casc_r, sw_r} = rise;

  daq_rise_det #(.W(NEDGE)) u_rise (
    .clk(clk), .rst(rst), .lvl(lvl), .rise(rise)
  );

  assign sw_ok   = sw_r;
  assign casc_ok = casc_r & ctl_casc_en;
  assign hw_ok   = hw_r & (ctl_auto_rearm | armed_q);
  assign any_ok  = sw_ok | casc_ok | hw_ok;
  assign frz_ok  = swf_r | (hwf_r & ctl_hw_freeze_en);

  always_ff @(posedge clk) begin
    if (rst)        armed_q <= 1'b0;
    else if (arm_r) armed_q <= 1'b1;
    else if (hw_ok) armed_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_pulse <= 1'b0;
      freeze_req <= 1'b0;
    end else begin
      trig_pulse <= any_ok;
      freeze_req <= frz_ok;
    end
  end

  assign evt = {frz_ok, any_ok, hw_ok, casc_ok, sw_ok};

  daq_sticky_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .clr(clr_r), .evt(evt), .flags(flg)
  );

  assign status = {flg[4], flg[3], armed_q, flg[2], flg[1], flg[0]};

  daq_trig_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .inc(any_ok), .cnt(trig_count)
  );
endmodule

// File: rtl/daq_trig_ctrl_chk.sv
module daq_trig_ctrl_chk
  import daq_trig_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_clr,
  input logic             hw_trig_in,
  input logic             trig_pulse,
  input logic             freeze_req,
  input logic [STS_W-1:0] status,
  input logic [CW-1:0]    trig_count
);
  assert_pulse_flag_R1: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> status[STS_ANY]);

  assert_pulse_source_R2: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> (status[STS_SW] | status[STS_CASC] | status[STS_HW]));

  assert_armed_drop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(status[STS_ARMED]) |-> $past(hw_trig_in));

  assert_sticky_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(status[STS_ANY]) |-> ($past(ctl_clr) && !$past(ctl_clr, 2)));

  assert_freeze_flag_R6: assert property (@(posedge clk) disable iff (rst)
    freeze_req |-> status[STS_FREEZE]);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (trig_count - $past(trig_count)) == {{(CW-1){1'b0}}, trig_pulse});
endmodule

bind daq_trig_ctrl daq_trig_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ctl_clr(ctl_clr), .hw_trig_in(hw_trig_in),
  .trig_pulse(trig_pulse), .freeze_req(freeze_req),
  .status(status), .trig_count(trig_count)
);

// File: tb/daq_trig_ctrl_bench.sv
module daq_trig_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw = 0, cen = 0, ar = 0, arm = 0, clr = 0, swf = 0, hfen = 0;
  logic casc = 0, hw = 0, hwf = 0;
  logic        trig_pulse, freeze_req;
  logic [5:0]  status;
  logic [31:0] trig_count;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  daq_trig_ctrl u_daq_trig_ctrl (
    .clk(clk), .rst(rst), .ctl_sw_trig(sw), .ctl_casc_en(cen),
    .ctl_auto_rearm(ar), .ctl_arm(arm), .ctl_clr(clr),
    .ctl_sw_freeze(swf), .ctl_hw_freeze_en(hfen),
    .casc_trig_in(casc), .hw_trig_in(hw), .hw_freeze_in(hwf),
    .trig_pulse(trig_pulse), .freeze_req(freeze_req),
    .status(status), .trig_count(trig_count)
  );

  // behavioural reference
  bit p_sw, p_casc, p_hw, p_arm, p_clr, p_swf, p_hwf;
  bit m_pulse, m_frz, m_armed;
  bit [5:0] m_sts;
  longint m_cnt;

  always @(posedge clk) begin
    bit e_sw, e_casc, e_hw, e_any, e_frz, r_clr, r_arm;
    if (rst) begin
      {p_sw, p_casc, p_hw, p_arm, p_clr, p_swf, p_hwf} = '0;
      m_pulse = 0; m_frz = 0; m_armed = 0; m_sts = '0; m_cnt = 0;
    end else begin
      e_sw   = sw && !p_sw;
      e_casc = casc && !p_casc && cen;
      e_hw   = hw && !p_hw && (ar || m_armed);
      e_any  = e_sw || e_casc || e_hw;
      e_frz  = (swf && !p_swf) || (hwf && !p_hwf && hfen);
      r_clr  = clr && !p_clr;
      r_arm  = arm && !p_arm;
      if (r_clr) begin
        m_sts[0] = 0; m_sts[1] = 0; m_sts[2] = 0; m_sts[4] = 0; m_sts[5] = 0;
      end
      if (e_sw)   m_sts[0] = 1;
      if (e_casc) m_sts[1] = 1;
      if (e_hw)   m_sts[2] = 1;
      if (e_any)  m_sts[4] = 1;
      if (e_frz)  m_sts[5] = 1;
      if (r_arm) m_armed = 1;
      else if (e_hw) m_armed = 0;
      m_sts[3] = m_armed;
      m_pulse = e_any;
      m_frz   = e_frz;
      if (e_any) m_cnt = (m_cnt + 1) % 64'h1_0000_0000;
      {p_sw, p_casc, p_hw, p_arm, p_clr, p_swf, p_hwf} =
        {sw, casc, hw, arm, clr, swf, hwf};
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R1 R2 R3 trig_pulse", trig_pulse, m_pulse);
      chk("R6 freeze_req", freeze_req, m_frz);
      chk("R5 status sw", status[0], m_sts[0]);
      chk("R2 status casc", status[1], m_sts[1]);
      chk("R3 status hw", status[2], m_sts[2]);
      chk("R4 status armed", status[3], m_sts[3]);
      chk("R5 status any", status[4], m_sts[4]);
      chk("R6 status freeze", status[5], m_sts[5]);
      chk("R7 trig_count", trig_count, m_cnt);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    // R8: reset state
    chk("R8 reset status", status, 0);
    chk("R8 reset count", trig_count, 0);
    rst = 0; tick(2);
    // R1: held software bit, one pulse
    sw = 1; tick(5); sw = 0; tick(2);
    // R2: cascade masked then enabled
    casc = 1; tick(2); casc = 0; tick(1);
    chk("R2 masked cascade ignored", status[1], 0);
    cen = 1; casc = 1; tick(2); casc = 0; tick(2);
    // R3: unarmed hardware ignored
    hw = 1; tick(2); hw = 0; tick(1);
    chk("R3 unarmed hw ignored", status[2], 0);
    // R4: arm, fire, consumed
    arm = 1; tick(2); arm = 0; hw = 1; tick(2); hw = 0; tick(1);
    hw = 1; tick(2); hw = 0; tick(1);
    // R4: arm edge and hw fire together
    arm = 1; tick(1); arm = 0; tick(1);
    arm = 1; hw = 1; tick(2); arm = 0; hw = 0; tick(2);
    // R3: auto-rearm
    ar = 1; repeat (3) begin hw = 1; tick(1); hw = 0; tick(1); end
    ar = 0;
    // R5: clear, and clear colliding with an event
    clr = 1; tick(2); clr = 0; tick(1);
    sw = 1; clr = 1; tick(2); sw = 0; clr = 0; tick(2);
    // R6: freeze paths
    swf = 1; tick(2); swf = 0; hwf = 1; tick(2); hwf = 0;
    hfen = 1; hwf = 1; tick(2); hwf = 0; tick(2);
    // random toggling
    for (int i = 0; i < 4000; i++) begin
      sw = ($urandom_range(0, 7) == 0); casc = ($urandom_range(0, 5) == 0);
      hw = ($urandom_range(0, 4) == 0); arm = ($urandom_range(0, 9) == 0);
      clr = ($urandom_range(0, 11) == 0); swf = ($urandom_range(0, 13) == 0);
      hwf = ($urandom_range(0, 6) == 0);
      cen = ($urandom_range(0, 1) == 0); ar = ($urandom_range(0, 3) == 0);
      hfen = ($urandom_range(0, 1) == 0);
      if (i == 2000) rst = 1;
      if (i == 2003) rst = 0;
      tick(1);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    done = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule